// File: doc/BRIEF.md
# Two-Level Cache Miss Profiler

This unit models the tag state of a two-level cache hierarchy and counts misses. It does not move data. The first level is split into a fetch cache and a data cache. Both are backed by one shared last-level cache. Each of the three caches has its own set count, way count and line size, fixed by parameters. Every set keeps its ways in recency order: the most recently used way is at the front, and a miss evicts the way at the back.

Two request ports feed the unit. One carries instruction fetches and the other carries data references. Each request carries a byte address and a byte count. A reference is looked up in its own first-level cache first. The shared last level is consulted only when that first-level lookup misses. Four saturating counters record first-level and last-level misses for each port.

A reference may cross into a second line. In that case both lines are looked up and updated, but the reference still counts as one reference. The unit handles one reference at a time, stepping through at most four single-set lookups. Fetch requests win over data requests that arrive in the same cycle.

Top module: `miss_profiler`

## Requirements
- R1: After reset all four counters read zero, every cache is empty, and both ready outputs are high while idle.
- R2: A fetch that hits in the fetch cache changes no counter. A fetch that misses adds one to the fetch first-level counter and triggers a last-level lookup. A byte count of 0 is treated as 1.
- R3: A last-level miss that follows a first-level miss adds one to the last-level counter of the port that issued the reference. A last-level hit adds nothing. A port's last-level count never exceeds its first-level count.
- R4: Data references take the same path through the data first-level cache and the same shared last level. A line brought into the last level by a fetch therefore hits there for a later data reference.
- R5: Each set is kept in recency order. A hit moves the line to the front. A miss inserts the line at the front and drops the least recently used line. The set index is the low bits of the block number (address divided by line size), and the whole block number is stored as the tag.
- R6: A reference whose last byte lies in the next line looks up and updates both lines. It adds at most one to the first-level counter: one if either line misses, zero if both hit.
- R7: When a crossing reference misses at the first level, both lines are looked up in the last level. The reference adds at most one to the last-level counter.
- R8: When both ports present a request in the same cycle, the fetch is accepted. `data_ready` stays low and the data request waits until the fetch has finished.
- R9: Counters are CNT_W bits wide and hold at all-ones instead of wrapping.
- R10: When the fetch and last-level line sizes are equal, a fetch that stays within one line indexes the last level with its first-level block number. A later fetch of an evicted line then hits in the last level.
- R11: While a reference is in progress, both ready outputs are low and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch request accepted this cycle when valid |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_size | input | SIZE_W | Fetch byte count |
| data_valid | input | 1 | Data request present |
| data_ready | output | 1 | Data request accepted this cycle when valid |
| data_addr | input | ADDR_W | Data byte address |
| data_size | input | SIZE_W | Data byte count |
| fetch_l1_miss_cnt | output | CNT_W | Fetch first-level misses |
| fetch_ll_miss_cnt | output | CNT_W | Last-level misses caused by fetches |
| data_l1_miss_cnt | output | CNT_W | Data first-level misses |
| data_ll_miss_cnt | output | CNT_W | Last-level misses caused by data references |

## Verification
The bench drives a two-way set through hit, fill and eviction. A design that evicted in fill order rather than by recency would miss on a line that had just been touched.

Crossing references are tested three ways: both lines missing, one line hitting and one missing, and both lines hitting at the first level with both hitting at the last level. A design that counted per line rather than per reference would report two misses instead of one.

A fetch and a data request are raised together to check that the data request is held off and then completed later. A second instance with a two-bit counter width checks that the counters stop at all-ones, where a wrapping counter would read back a small value.

// File: rtl/prof_pkg.sv
package prof_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1A  = 3'd1,
        ST_L1B  = 3'd2,
        ST_LLA  = 3'd3,
        ST_LLB  = 3'd4
    } prof_state_e;

    typedef enum logic {
        SRC_FETCH = 1'b0,
        SRC_DATA  = 1'b1
    } req_src_e;

endpackage

// File: rtl/lru_tag_cache.sv
module lru_tag_cache #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [BLK_W-1:0] lk_block,
    output logic             lk_miss
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

    logic [BLK_W-1:0] tag_q [SETS][WAYS];
    logic [BLK_W-1:0] tag_d [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  vld_d [SETS];
    logic [WAYS-1:0]  hit_vec;
    logic [IDX_W-1:0] idx;
    int               hit_pos;

    assign idx = (SETS > 1) ? lk_block[IDX_W-1:0] : '0;

    always_comb begin
        hit_pos = WAYS - 1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == lk_block);
            if (hit_vec[w]) hit_pos = w;
        end
        lk_miss = ~|hit_vec;
    end

    // Next state: move the hit way (or the LRU way on a miss) to the front
    always_comb begin
        tag_d = tag_q;
        vld_d = vld_q;
        if (lk_valid) begin
            for (int w = WAYS - 1; w > 0; w--) begin
                if (w <= hit_pos) begin
                    tag_d[idx][w] = tag_q[idx][w-1];
                    vld_d[idx][w] = vld_q[idx][w-1];
                end
            end
            tag_d[idx][0] = lk_block;
            vld_d[idx][0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            tag_q <= tag_d;
            vld_q <= vld_d;
        end
    end

    AST_MRU_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (vld_q[$past(idx)][0] && tag_q[$past(idx)][0] == $past(lk_block))); // R5
    AST_UNIQUE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) <= 1); // R5

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {W{1'b1}}) |=> (cnt_q == {W{1'b1}})); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/miss_profiler.sv
module miss_profiler
    import prof_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 4,
    parameter int CNT_W    = 64,
    parameter int L1I_SETS = 4,
    parameter int L1I_WAYS = 2,
    parameter int L1I_LINE = 16,
    parameter int L1D_SETS = 4,
    parameter int L1D_WAYS = 2,
    parameter int L1D_LINE = 16,
    parameter int LL_SETS  = 8,
    parameter int LL_WAYS  = 4,
    parameter int LL_LINE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [SIZE_W-1:0] fetch_size,
    input  logic              data_valid,
    output logic              data_ready,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [SIZE_W-1:0] data_size,
    output logic [CNT_W-1:0]  fetch_l1_miss_cnt,
    output logic [CNT_W-1:0]  fetch_ll_miss_cnt,
    output logic [CNT_W-1:0]  data_l1_miss_cnt,
    output logic [CNT_W-1:0]  data_ll_miss_cnt
);
    localparam int  L1I_LB     = $clog2(L1I_LINE);
    localparam int  L1D_LB     = $clog2(L1D_LINE);
    localparam int  LL_LB      = $clog2(LL_LINE);
    localparam bit  SAME_ILINE = (L1I_LINE == LL_LINE);

    typedef struct packed {
        prof_state_e       st;
        req_src_e          src;
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
        logic              miss;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [ADDR_W-1:0] i_blk_a, i_blk_b, d_blk_a, d_blk_b;
    logic [ADDR_W-1:0] l1_blk_a, l1_blk_b, l1_blk_cur;
    logic [ADDR_W-1:0] ll_blk_a, ll_blk_b, ll_blk_cur;
    logic              l1_strad, ll_strad;
    logic              l1i_lk, l1d_lk, ll_lk;
    logic              l1i_miss, l1d_miss, ll_miss, l1_miss_now;
    logic              inc_fl1, inc_fll, inc_dl1, inc_dll;
    logic              inc_l1, inc_ll;

    // Block numbers of the first and last byte, per cache line size
    assign i_blk_a  = c_q.first >> L1I_LB;
    assign i_blk_b  = c_q.last  >> L1I_LB;
    assign d_blk_a  = c_q.first >> L1D_LB;
    assign d_blk_b  = c_q.last  >> L1D_LB;
    assign l1_blk_a = (c_q.src == SRC_FETCH) ? i_blk_a : d_blk_a;
    assign l1_blk_b = (c_q.src == SRC_FETCH) ? i_blk_b : d_blk_b;
    assign l1_strad = (l1_blk_a != l1_blk_b);

    generate
        if (SAME_ILINE) begin : g_fetch_shortcut
            // Equal line sizes: a single-line fetch reuses its first-level block
            assign ll_blk_a = (c_q.src == SRC_FETCH) ? i_blk_a : (c_q.first >> LL_LB);
            assign ll_blk_b = (c_q.src == SRC_FETCH && !l1_strad) ? i_blk_a
                                                                  : (c_q.last >> LL_LB);
            assign ll_strad = (c_q.src == SRC_FETCH && !l1_strad) ? 1'b0
                                                                  : (ll_blk_a != ll_blk_b);
        end else begin : g_fetch_generic
            assign ll_blk_a = c_q.first >> LL_LB;
            assign ll_blk_b = c_q.last  >> LL_LB;
            assign ll_strad = (ll_blk_a != ll_blk_b);
        end
    endgenerate

    assign l1_blk_cur  = (c_q.st == ST_L1B) ? l1_blk_b : l1_blk_a;
    assign ll_blk_cur  = (c_q.st == ST_LLB) ? ll_blk_b : ll_blk_a;
    assign l1i_lk      = (c_q.st == ST_L1A || c_q.st == ST_L1B) && (c_q.src == SRC_FETCH);
    assign l1d_lk      = (c_q.st == ST_L1A || c_q.st == ST_L1B) && (c_q.src == SRC_DATA);
    assign ll_lk       = (c_q.st == ST_LLA || c_q.st == ST_LLB);
    assign l1_miss_now = (c_q.src == SRC_FETCH) ? l1i_miss : l1d_miss;

    assign fetch_ready = (c_q.st == ST_IDLE);
    assign data_ready  = (c_q.st == ST_IDLE) && !fetch_valid;

    always_comb begin
        c_d    = c_q;
        inc_l1 = 1'b0;
        inc_ll = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                c_d.miss = 1'b0;
                if (fetch_valid) begin
                    c_d.st    = ST_L1A;
                    c_d.src   = SRC_FETCH;
                    c_d.first = fetch_addr;
                    c_d.last  = fetch_addr + ((fetch_size == '0) ? '0
                                : ADDR_W'(fetch_size - 1'b1));
                end else if (data_valid) begin
                    c_d.st    = ST_L1A;
                    c_d.src   = SRC_DATA;
                    c_d.first = data_addr;
                    c_d.last  = data_addr + ((data_size == '0) ? '0
                                : ADDR_W'(data_size - 1'b1));
                end
            end
            ST_L1A: begin
                if (l1_strad) begin
                    c_d.miss = l1_miss_now;
                    c_d.st   = ST_L1B;
                end else if (l1_miss_now) begin
                    inc_l1   = 1'b1;
                    c_d.miss = 1'b0;
                    c_d.st   = ST_LLA;
                end else begin
                    c_d.st   = ST_IDLE;
                end
            end
            ST_L1B: begin
                if (c_q.miss || l1_miss_now) begin
                    inc_l1   = 1'b1;
                    c_d.miss = 1'b0;
                    c_d.st   = ST_LLA;
                end else begin
                    c_d.st   = ST_IDLE;
                end
            end
            ST_LLA: begin
                if (ll_strad) begin
                    c_d.miss = ll_miss;
                    c_d.st   = ST_LLB;
                end else begin
                    inc_ll   = ll_miss;
                    c_d.st   = ST_IDLE;
                end
            end
            ST_LLB: begin
                inc_ll = c_q.miss || ll_miss;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= ST_IDLE;
            c_q.src   <= SRC_FETCH;
            c_q.first <= '0;
            c_q.last  <= '0;
            c_q.miss  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign inc_fl1 = inc_l1 && (c_q.src == SRC_FETCH);
    assign inc_dl1 = inc_l1 && (c_q.src == SRC_DATA);
    assign inc_fll = inc_ll && (c_q.src == SRC_FETCH);
    assign inc_dll = inc_ll && (c_q.src == SRC_DATA);

    lru_tag_cache #(.SETS(L1I_SETS), .WAYS(L1I_WAYS), .BLK_W(ADDR_W)) u_l1_fetch (
        .clk(clk), .rst_n(rst_n), .lk_valid(l1i_lk), .lk_block(l1_blk_cur), .lk_miss(l1i_miss));
    lru_tag_cache #(.SETS(L1D_SETS), .WAYS(L1D_WAYS), .BLK_W(ADDR_W)) u_l1_data (
        .clk(clk), .rst_n(rst_n), .lk_valid(l1d_lk), .lk_block(l1_blk_cur), .lk_miss(l1d_miss));
    lru_tag_cache #(.SETS(LL_SETS), .WAYS(LL_WAYS), .BLK_W(ADDR_W)) u_last (
        .clk(clk), .rst_n(rst_n), .lk_valid(ll_lk), .lk_block(ll_blk_cur), .lk_miss(ll_miss));

    sat_counter #(.W(CNT_W)) u_cnt_fl1 (.clk(clk), .rst_n(rst_n), .inc(inc_fl1), .count(fetch_l1_miss_cnt));
    sat_counter #(.W(CNT_W)) u_cnt_fll (.clk(clk), .rst_n(rst_n), .inc(inc_fll), .count(fetch_ll_miss_cnt));
    sat_counter #(.W(CNT_W)) u_cnt_dl1 (.clk(clk), .rst_n(rst_n), .inc(inc_dl1), .count(data_l1_miss_cnt));
    sat_counter #(.W(CNT_W)) u_cnt_dll (.clk(clk), .rst_n(rst_n), .inc(inc_dll), .count(data_ll_miss_cnt));

    AST_FETCH_LL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ll_miss_cnt <= fetch_l1_miss_cnt); // R3
    AST_DATA_LL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        data_ll_miss_cnt <= data_l1_miss_cnt); // R3
    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && fetch_valid && data_valid) |=> (c_q.src == SRC_FETCH)); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != ST_IDLE && c_q.st != ST_LLB && c_q.st != ST_LLA && c_q.st != ST_L1B)
        |=> $stable(c_q.first)); // R11
    AST_ONE_LL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_fll |=> $stable(fetch_ll_miss_cnt) || (c_q.st == ST_IDLE)); // R7

endmodule

// File: tb/miss_profiler_tb_top.sv
module miss_profiler_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [3:0]  fetch_size = '0;
    logic        data_valid = 1'b0;
    logic [31:0] data_addr = '0;
    logic [3:0]  data_size = '0;
    logic        fetch_ready, data_ready, s_fready, s_dready;
    logic [63:0] f_l1, f_ll, d_l1, d_ll;
    logic [1:0]  s_fl1, s_fll, s_dl1, s_dll;

    int n_chk = 0;
    int n_bad = 0;
    longint e_fl1 = 0, e_fll = 0, e_dl1 = 0, e_dll = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    miss_profiler dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_size(fetch_size),
        .data_valid(data_valid), .data_ready(data_ready),
        .data_addr(data_addr), .data_size(data_size),
        .fetch_l1_miss_cnt(f_l1), .fetch_ll_miss_cnt(f_ll),
        .data_l1_miss_cnt(d_l1), .data_ll_miss_cnt(d_ll));

    miss_profiler #(.CNT_W(2)) dut_sat (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(s_fready),
        .fetch_addr(fetch_addr), .fetch_size(fetch_size),
        .data_valid(data_valid), .data_ready(s_dready),
        .data_addr(data_addr), .data_size(data_size),
        .fetch_l1_miss_cnt(s_fl1), .fetch_ll_miss_cnt(s_fll),
        .data_l1_miss_cnt(s_dl1), .data_ll_miss_cnt(s_dll));

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check({req, " fetch L1"}, longint'(f_l1), e_fl1);
        check({req, " fetch LL"}, longint'(f_ll), e_fll);
        check({req, " data L1"},  longint'(d_l1), e_dl1);
        check({req, " data LL"},  longint'(d_ll), e_dll);
    endtask

    task automatic wait_idle();
        while (!fetch_ready) @(negedge clk);
    endtask

    task automatic issue(input bit is_data, input logic [31:0] a, input logic [3:0] s);
        @(negedge clk);
        wait_idle();
        if (is_data) begin
            data_addr = a; data_size = s; data_valid = 1'b1;
        end else begin
            fetch_addr = a; fetch_size = s; fetch_valid = 1'b1;
        end
        @(negedge clk);
        fetch_valid = 1'b0;
        data_valid  = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        check("R1 fetch_ready", longint'(fetch_ready), 1);
        check("R1 data_ready", longint'(data_ready), 1);
        check_counts("R1");
    endtask

    task automatic t_fetch_basic();
        issue(1'b0, 32'h000, 4'd4); e_fl1++; e_fll++;
        check_counts("R2 R3 cold fetch");
        check("R9 narrow before saturation", longint'(s_fl1), 1);
        issue(1'b0, 32'h004, 4'd0); // R2 size 0 treated as 1, same line hit
        check_counts("R2 fetch hit");
    endtask

    task automatic t_data_shared();
        issue(1'b1, 32'h000, 4'd4); e_dl1++;
        check_counts("R4 data hits line fetched into LL");
        issue(1'b1, 32'h100, 4'd4); e_dl1++; e_dll++;
        check_counts("R4 R3 data cold miss");
    endtask

    task automatic t_lru();
        issue(1'b1, 32'h000, 4'd4);
        check_counts("R5 hit moves to front");
        issue(1'b1, 32'h200, 4'd4); e_dl1++; e_dll++;
        check_counts("R5 fill evicts LRU");
        issue(1'b1, 32'h000, 4'd4);
        check_counts("R5 recently used line kept");
        issue(1'b1, 32'h100, 4'd4); e_dl1++;
        check_counts("R5 evicted line misses L1, hits LL");
    endtask

    task automatic t_shortcut();
        issue(1'b0, 32'h100, 4'd4); e_fl1++;
        check_counts("R10 fetch uses block number in LL");
    endtask

    task automatic t_straddle();
        issue(1'b0, 32'h03C, 4'd8); e_fl1++; e_fll++;
        check_counts("R6 R7 both lines miss counts once");
        issue(1'b0, 32'h03C, 4'd8);
        check_counts("R6 both lines hit");
        issue(1'b0, 32'h04C, 4'd8); e_fl1++; e_fll++;
        check_counts("R6 R7 one line hits one misses");
        issue(1'b1, 32'h03C, 4'd8); e_dl1++;
        check_counts("R7 L1 miss with both LL lines hit");
    endtask

    task automatic t_priority();
        @(negedge clk);
        wait_idle();
        fetch_addr = 32'h000; fetch_size = 4'd4; fetch_valid = 1'b1;
        data_addr  = 32'h300; data_size  = 4'd4; data_valid  = 1'b1;
        #1;
        check("R8 fetch_ready on collision", longint'(fetch_ready), 1);
        check("R8 data_ready held low", longint'(data_ready), 0);
        @(negedge clk);
        fetch_valid = 1'b0;
        check("R11 fetch_ready low while busy", longint'(fetch_ready), 0);
        check("R11 data_ready low while busy", longint'(data_ready), 0);
        while (!data_ready) @(negedge clk);
        e_fl1++;
        check_counts("R8 fetch served first");
        @(negedge clk);
        data_valid = 1'b0;
        wait_idle();
        e_dl1++; e_dll++;
        check_counts("R8 waiting data served");
    endtask

    task automatic t_saturate();
        check("R9 fetch L1 saturates", longint'(s_fl1), 3);
        check("R9 fetch LL saturates", longint'(s_fll), 3);
        check("R9 data L1 saturates", longint'(s_dl1), 3);
        check("R9 data LL saturates", longint'(s_dll), 3);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fetch_basic();
        t_data_shared();
        t_lru();
        t_shortcut();
        t_straddle();
        t_priority();
        t_saturate();
        finish_run();
    end

endmodule